// File: doc/BRIEF.md
# Serial Sample Receiver for a DAC Core

This block takes 16-bit signed samples that arrive over a three-wire serial link and hands them, as a parallel word, to a digital-to-analog converter core. The three wires are a bit clock, a data line and a latch line. All three are asynchronous to the block. They pass through synchronizers clocked by a fast system clock, which must run at least four times the bit rate, and the block looks for their falling edges.

On every falling bit-clock edge one data bit enters a shift register. The sign bit arrives first. The register always holds the sixteen bits received most recently. On a falling edge of the latch line, the current contents of the register move into a holding register that drives the converter. The block keeps no bit count and no frame state. If a host pulses the latch line at the start of each new word, the word that was just finished is committed, so there is one word of latency.

The outputs are the held two's-complement word, the same word in offset-binary form (sign bit inverted), and a strobe that is high for one system cycle after each commit.

Top module: `serial_dac_rx`

## Requirements
- R1: A synchronous active-high `rst` sets the held word to 0x0000 and the offset-binary output to 0x8000, and keeps `sampleStrobe` low.
- R2: Each falling edge of `serClk` shifts the level of `serData` into bit 0 of the shift register, so the first bit of a word ends up as bit 15 (the sign bit). Rising edges of `serClk` shift nothing.
- R3: When more than 16 bits are sent before a commit, only the last 16 bits received are committed. Older bits are discarded off the top.
- R4: The held word changes only on a falling edge of `serLatch`. Rising edges of `serLatch`, and bits shifted in without a commit, leave the outputs unchanged.
- R5: `offsetWord` equals `sampleWord` with bit 15 inverted.
- R6: `sampleStrobe` is high for exactly one system cycle per falling `serLatch` edge, in the same cycle that the new word first appears.
- R7: When a falling `serClk` edge and a falling `serLatch` edge are detected in the same system cycle, the shift happens first and the commit captures the word that includes the new bit.
- R8: A second falling `serLatch` edge with no bits shifted in between commits the same word again and still produces a strobe.
- R9: Committing the all-zero word gives `sampleWord` = 0x0000 and `offsetWord` = 0x8000 (midscale).
- R10: When the latch is pulsed low at the start of each word (continuous framing), every commit delivers the word completed just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| serClk | input | 1 | Serial bit clock (asynchronous) |
| serData | input | 1 | Serial data, sampled on falling `serClk` |
| serLatch | input | 1 | Latch line; a falling edge commits the word |
| sampleWord | output | 16 | Committed two's-complement sample |
| offsetWord | output | 16 | Committed sample in offset-binary form |
| sampleStrobe | output | 1 | One-cycle pulse after each commit |

## Verification
The assertions check the following on every cycle:
- A detected bit-clock edge lands the synchronized data bit at the bottom of the shift register.
- The held word never changes without a strobe.
- Each commit produces a strobe one cycle later, and the strobe never lasts two cycles.
- When both edges fall together, the commit takes the freshly shifted bit.

Other behaviour only the bench scenarios can show: the MSB-first ordering across whole words, discarding of bits beyond sixteen, the one-word latency under continuous framing, the midscale code, and the reset values at the ports.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic shiftEn;
    logic latchEn;
  } sdr_strobe_t;
endpackage

// File: rtl/sdr_edge_sync.sv
module sdr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic fallOut
);
  localparam int unsigned CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[CHAIN_W-2:0], rawIn};
  end

  // the oldest stage is the previous synchronized sample
  assign fallOut = chain[CHAIN_W-1] & ~chain[CHAIN_W-2];
endmodule

// File: rtl/sdr_ctrl.sv
module sdr_ctrl
  import sdr_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLatch,
  output sdr_strobe_t strobes,
  output logic        dataBit
);
  localparam int unsigned EDGE_N = 2;

  logic [EDGE_N-1:0] rawLines;
  logic [EDGE_N-1:0] falls;
  logic [STAGES-1:0] dataChain;

  assign rawLines = {serLatch, serClk};

  for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
    sdr_edge_sync #(.STAGES(STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .rawIn   (rawLines[g]),
      .fallOut (falls[g])
    );
  end

  // data runs through the same depth so it lines up with the clock edge
  always_ff @(posedge clk) begin
    if (rst) dataChain <= '0;
    else     dataChain <= {dataChain[STAGES-2:0], serData};
  end

  assign dataBit         = dataChain[STAGES-1];
  assign strobes.shiftEn = falls[0];
  assign strobes.latchEn = falls[1];
endmodule

// File: rtl/sdr_datapath.sv
module sdr_datapath
  import sdr_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic        clk,
  input  logic        rst,
  input  sdr_strobe_t strobes,
  input  logic        dataBit,
  output logic [W-1:0] holdWord,
  output logic        updStrobe
);
  logic [W-1:0] shiftReg;
  logic [W-1:0] shiftNext;

  always_comb begin
    shiftNext = shiftReg;
    if (strobes.shiftEn) shiftNext = {shiftReg[W-2:0], dataBit};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg  <= '0;
      holdWord  <= '0;
      updStrobe <= 1'b0;
    end else begin
      shiftReg  <= shiftNext;
      updStrobe <= strobes.latchEn;
      if (strobes.latchEn) holdWord <= shiftNext;
    end
  end

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftEn |=> shiftReg[0] == $past(dataBit));

  // R4
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !updStrobe |-> $stable(holdWord));

  // R7
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.shiftEn && strobes.latchEn) |=> holdWord[0] == $past(dataBit));
endmodule

// File: rtl/serial_dac_rx.sv
module serial_dac_rx
  import sdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLatch,
  output logic [WORD_W-1:0] sampleWord,
  output logic [WORD_W-1:0] offsetWord,
  output logic              sampleStrobe
);
  sdr_strobe_t strobes;
  logic        dataBit;

  sdr_ctrl #(.STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .serClk   (serClk),
    .serData  (serData),
    .serLatch (serLatch),
    .strobes  (strobes),
    .dataBit  (dataBit)
  );

  sdr_datapath #(.W(WORD_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .dataBit   (dataBit),
    .holdWord  (sampleWord),
    .updStrobe (sampleStrobe)
  );

  assign offsetWord = {~sampleWord[WORD_W-1], sampleWord[WORD_W-2:0]};

  // R6
  strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.latchEn |=> sampleStrobe);

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    sampleStrobe |=> !sampleStrobe);
endmodule

// File: tb/serial_dac_rx_bench.sv
module serial_dac_rx_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serClk = 1'b1;
  logic serData = 1'b0;
  logic serLatch = 1'b1;
  logic [15:0] sampleWord, offsetWord;
  logic sampleStrobe;

  int checks = 0;
  int failures = 0;
  int strobeCount = 0;
  int expStrobes = 0;
  logic [15:0] modelShift = '0;
  logic [15:0] modelHold = '0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  serial_dac_rx u_serial_dac_rx (
    .clk(clk), .rst(rst), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .sampleWord(sampleWord), .offsetWord(offsetWord),
    .sampleStrobe(sampleStrobe)
  );

  always @(negedge clk) if (!rst && sampleStrobe) strobeCount++;

  function automatic logic [15:0] toOffset(input logic [15:0] w);
    return {~w[15], w[14:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    serData = b; serClk = 1'b1; waitCyc(4);
    serClk = 1'b0; waitCyc(4);
    modelShift = {modelShift[14:0], b};
  endtask

  task automatic sendWord(input logic [15:0] w, input int nBits);
    for (int i = nBits - 1; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic pulseLatch();
    serLatch = 1'b1; waitCyc(4);
    serLatch = 1'b0; waitCyc(6);
    modelHold = modelShift;
    expStrobes++;
  endtask

  task automatic checkOut(input string req);
    check(req, {16'h0, sampleWord}, {16'h0, modelHold});
    check("R5", {16'h0, offsetWord}, {16'h0, toOffset(modelHold)});
    check("R6", strobeCount, expStrobes);
  endtask

  initial begin
    int seedVal;
    logic [15:0] prevWord;
    seedVal = $urandom(32'h5eed_0042);
    waitCyc(5);
    // R1 reset values
    check("R1", {16'h0, sampleWord}, 32'h0);
    check("R1", {16'h0, offsetWord}, 32'h8000);
    check("R1", {31'h0, sampleStrobe}, 32'h0);
    rst = 1'b0;
    serLatch = 1'b0; serClk = 1'b0; waitCyc(6);
    check("R4", {16'h0, sampleWord}, 32'h0);

    // R2 MSB first, directed
    serClk = 1'b1; waitCyc(4);
    sendWord(16'h8001, 16); pulseLatch(); checkOut("R2");
    sendWord(16'h7ffe, 16); pulseLatch(); checkOut("R2");

    // R4 bits without commit, and a lone rising latch edge
    sendWord(16'h1234, 16);
    check("R4", {16'h0, sampleWord}, {16'h0, modelHold});
    serLatch = 1'b1; waitCyc(8);
    check("R4", {16'h0, sampleWord}, {16'h0, modelHold});
    check("R4", strobeCount, expStrobes);
    serLatch = 1'b0; waitCyc(6);
    modelHold = modelShift; expStrobes++;
    checkOut("R4");

    // R3 more than 16 bits
    sendWord(16'hdead, 16); sendWord(16'h0beef >> 4, 11);
    pulseLatch(); checkOut("R3");

    // R8 recommit without new bits
    pulseLatch(); checkOut("R8");

    // R9 midscale
    sendWord(16'h0000, 16); pulseLatch(); checkOut("R9");
    check("R9", {16'h0, offsetWord}, 32'h8000);

    // R7 simultaneous falling edges
    sendWord(16'h0aaa, 15);
    serLatch = 1'b1; serData = 1'b1; serClk = 1'b1; waitCyc(4);
    serClk = 1'b0; serLatch = 1'b0; waitCyc(6);
    modelShift = {modelShift[14:0], 1'b1};
    modelHold = modelShift; expStrobes++;
    checkOut("R7");

    // R10 continuous framing: latch pulsed at start of each word
    prevWord = modelShift;
    for (int k = 0; k < 6; k++) begin
      logic [15:0] w;
      w = 16'($urandom);
      pulseLatch();
      check("R10", {16'h0, sampleWord}, {16'h0, prevWord});
      sendWord(w, 16);
      prevWord = w;
    end
    pulseLatch(); checkOut("R10");

    // random words
    for (int k = 0; k < 20; k++) begin
      sendWord(16'($urandom), 16);
      pulseLatch(); checkOut("R2");
    end

    // R1 reset again
    rst = 1'b1; waitCyc(3);
    check("R1", {16'h0, sampleWord}, 32'h0);
    check("R1", {16'h0, offsetWord}, 32'h8000);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule